// File: doc/BRIEF.md
# Compressed Field Size Limiter

This block sits on the output of an entropy coder and watches the coded words of one video field as they leave. It counts every word of the field and, once a programmable word budget has been used, replaces the payload of every further data word in that field with zero. Structural markers (end of block, end of field and any other marker code) are never altered, so a standard decoder still finds every block and field boundary. The stream carries fewer significant bits, and the structure stays intact.

Each word arrives with a two-bit kind tag: 0 is data, 1 is end of block, 2 is end of field, 3 is an auxiliary marker. The word tagged end of field closes the field. When that word leaves the block, a size register is loaded with the number of words in the closed field, and a flag is loaded that tells whether any data word of that field was zeroed. Both values hold until the next field closes. A zero limit, or a low enable, turns the limiter off.

Top module: `fsl_limiter`

## Requirements
- R1: Every input word appears at the output exactly one clock later, with out_valid following in_valid. A data word whose in-field index is below the limit passes unchanged.
- R2: While the limiter is active, a data word (kind 0) whose in-field index (0-based) is greater than or equal to cfg_limit is output as all-zero, and its kind stays 0.
- R3: Marker words (kind 1, 2 or 3) always pass with word and kind unchanged, and each counts as one word of the field.
- R4: The word after an end-of-field word (kind 2), and the first word after reset, has in-field index 0.
- R5: field_size is loaded with the number of words in the field, including its end-of-field word, in the same cycle that this word appears at the output. It holds until the next end-of-field word.
- R6: field_trunc is loaded with 1 if at least one data word of the closed field was zeroed, and with 0 otherwise. It is updated together with field_size.
- R7: The word count and the in-field index saturate at 2^CNT_W-1.
- R8: With cfg_en low or cfg_limit equal to 0, no word is modified.
- R9: After reset, out_valid, field_size and field_trunc are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word present |
| in_word | input | DATA_W | Coded word |
| in_kind | input | 2 | 0 data, 1 end of block, 2 end of field, 3 auxiliary marker |
| cfg_en | input | 1 | Limiter enable |
| cfg_limit | input | CNT_W | Word budget per field (0 = off) |
| out_valid | output | 1 | Output word present |
| out_word | output | DATA_W | Filtered word |
| out_kind | output | 2 | Kind of the output word |
| field_size | output | CNT_W | Word count of the last closed field |
| field_trunc | output | 1 | The last closed field was truncated |

## Verification
A wrong in-field index shows up at the boundary: the first zeroed data word comes one word early or late, and the size reported for that field is off. Both can be seen when that field's end-of-field word leaves the block. A field boundary that was not cleared makes the next field start its zeroing too early, or carries a false truncation flag into that field's report. The bench therefore runs fields back to back, with the budget hit exactly at a marker, just before one and not at all. It also runs one field long enough to saturate the count.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
   typedef enum logic [1:0] {
      WK_DATA = 2'd0,
      WK_EOB  = 2'd1,
      WK_EOF  = 2'd2,
      WK_AUX  = 2'd3
   } word_kind_e;

   function automatic logic is_data(input logic [1:0] k);
      return k == WK_DATA;
   endfunction

   function automatic logic is_field_end(input logic [1:0] k);
      return k == WK_EOF;
   endfunction
endpackage

// File: rtl/fsl_index_ctr.sv
module fsl_index_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   output logic [CNT_W-1:0] idx,
   output logic [CNT_W-1:0] idx_inc
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // saturating successor of the current index
   assign idx_inc = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (step)
         idx <= restart ? '0 : idx_inc;
   end
endmodule

// File: rtl/fsl_zero_gate.sv
module fsl_zero_gate #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_word,
   input  logic [1:0]        in_kind,
   input  logic              cfg_en,
   input  logic [CNT_W-1:0]  cfg_limit,
   input  logic [CNT_W-1:0]  idx,
   output logic [DATA_W-1:0] gated_word,
   output logic              zero_hit
);
   import fsl_pkg::*;

   logic armed;

   assign armed      = cfg_en && (cfg_limit != '0);
   assign zero_hit   = in_valid && armed && is_data(in_kind) && (idx >= cfg_limit);
   assign gated_word = zero_hit ? '0 : in_word;
endmodule

// File: rtl/fsl_stage.sv
module fsl_stage #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_word,
   input  logic [1:0]        d_kind,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_word,
   output logic [1:0]        q_kind
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid <= 1'b0;
               q_word  <= '0;
               q_kind  <= '0;
            end else begin
               q_valid <= d_valid;
               if (d_valid) begin
                  q_word <= d_word;
                  q_kind <= d_kind;
               end
            end
         end
      end else begin : g_thru
         assign q_valid = d_valid;
         assign q_word  = d_word;
         assign q_kind  = d_kind;
      end
   endgenerate
endmodule

// File: rtl/fsl_report.sv
module fsl_report #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_seen,
   input  logic             closes_field,
   input  logic             zero_hit,
   input  logic [CNT_W-1:0] closing_size,
   output logic [CNT_W-1:0] field_size,
   output logic             field_trunc
);
   logic cut_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cut_seen    <= 1'b0;
         field_size  <= '0;
         field_trunc <= 1'b0;
      end else if (word_seen) begin
         if (closes_field) begin
            field_size  <= closing_size;
            field_trunc <= cut_seen | zero_hit;
            cut_seen    <= 1'b0;
         end else if (zero_hit) begin
            cut_seen <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsl_limiter.sv
module fsl_limiter #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_word,
   input  logic [1:0]        in_kind,
   input  logic              cfg_en,
   input  logic [CNT_W-1:0]  cfg_limit,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_word,
   output logic [1:0]        out_kind,
   output logic [CNT_W-1:0]  field_size,
   output logic              field_trunc
);
   import fsl_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("fsl_limiter: CNT_W must be within 2..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("fsl_limiter: DATA_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0]  idx;
   logic [CNT_W-1:0]  idx_inc;
   logic [DATA_W-1:0] gated_word;
   logic              zero_hit;
   logic              closes;

   assign closes = is_field_end(in_kind);

   fsl_index_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (in_valid),
      .restart (closes),
      .idx     (idx),
      .idx_inc (idx_inc)
   );

   fsl_zero_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) gate_i (
      .in_valid   (in_valid),
      .in_word    (in_word),
      .in_kind    (in_kind),
      .cfg_en     (cfg_en),
      .cfg_limit  (cfg_limit),
      .idx        (idx),
      .gated_word (gated_word),
      .zero_hit   (zero_hit)
   );

   fsl_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) stage_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_word  (gated_word),
      .d_kind  (in_kind),
      .q_valid (out_valid),
      .q_word  (out_word),
      .q_kind  (out_kind)
   );

   fsl_report #(.CNT_W(CNT_W)) rep_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_seen    (in_valid),
      .closes_field (closes),
      .zero_hit     (zero_hit),
      .closing_size (idx_inc),
      .field_size   (field_size),
      .field_trunc  (field_trunc)
   );
endmodule

// File: rtl/fsl_limiter_chk.sv
module fsl_limiter_chk #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_word,
   input logic [1:0]        in_kind,
   input logic              cfg_en,
   input logic [CNT_W-1:0]  cfg_limit,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_word,
   input logic [1:0]        out_kind,
   input logic [CNT_W-1:0]  field_size,
   input logic              field_trunc
);
   generate
      if (OUT_REG) begin : g_chk
         // R1
         valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R1
         idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         // R3
         marker_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_kind != 2'd0) |=>
               (out_word == $past(in_word) && out_kind == $past(in_kind)));
         // R8
         bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (!cfg_en || cfg_limit == '0)) |=> (out_word == $past(in_word)));
         // R5
         size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_valid && in_kind == 2'd2) |=> ($stable(field_size) && $stable(field_trunc)));
         // R5
         size_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_kind == 2'd2) |=> (field_size != '0));
         // R6
         trunc_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(field_trunc) |-> (out_valid && out_kind == 2'd2));
      end
   endgenerate
endmodule

bind fsl_limiter fsl_limiter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .OUT_REG(OUT_REG)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_word     (in_word),
   .in_kind     (in_kind),
   .cfg_en      (cfg_en),
   .cfg_limit   (cfg_limit),
   .out_valid   (out_valid),
   .out_word    (out_word),
   .out_kind    (out_kind),
   .field_size  (field_size),
   .field_trunc (field_trunc)
);

// File: tb/fsl_limiter_tb_top.sv
module fsl_limiter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int CW = 6;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   typedef struct {
      logic [DW-1:0] word;
      logic [1:0]    kind;
      logic          closes;
      logic [CW-1:0] size;
      logic          trunc;
      logic          zeroed;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_word = '0;
   logic [1:0] in_kind = '0;
   logic cfg_en = 1'b0;
   logic [CW-1:0] cfg_limit = '0;
   logic out_valid;
   logic [DW-1:0] out_word;
   logic [1:0] out_kind;
   logic [CW-1:0] field_size;
   logic field_trunc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t sb[$];
   logic [CW-1:0] m_idx = '0;
   logic m_cut = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fsl_limiter #(.DATA_W(DW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_kind(in_kind), .cfg_en(cfg_en), .cfg_limit(cfg_limit),
      .out_valid(out_valid), .out_word(out_word), .out_kind(out_kind),
      .field_size(field_size), .field_trunc(field_trunc)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: pushes the expected item, then drives one word
   task automatic send(input logic [DW-1:0] w, input logic [1:0] k);
      exp_t e;
      e.word = w; e.kind = k; e.closes = (k == 2'd2); e.zeroed = 1'b0;
      e.size = '0; e.trunc = 1'b0;
      if (k == 2'd0 && cfg_en && cfg_limit != '0 && m_idx >= cfg_limit) begin
         e.word = '0; e.zeroed = 1'b1; m_cut = 1'b1;
      end
      if (e.closes) begin
         e.size = (m_idx == CMAX) ? CMAX : m_idx + 1'b1;
         e.trunc = m_cut;
         m_idx = '0; m_cut = 1'b0;
      end else begin
         m_idx = (m_idx == CMAX) ? CMAX : m_idx + 1'b1;
      end
      sb.push_back(e);
      @(negedge clk);
      in_valid = 1'b1; in_word = w; in_kind = k;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // field of n data words (value base+i), an end-of-block marker after every 'blk' data words, then end of field
   task automatic field(input int n, input int blk, input logic [DW-1:0] base);
      for (int i = 0; i < n; i++) begin
         send(base + i, 2'd0);
         if (blk != 0 && (i % blk) == blk - 1) send(32'hB10C_0000 + i, 2'd1);
      end
      send(32'hF1E1_D000, 2'd2);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R1 unexpected word", out_word, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.kind != 2'd0)
               check(out_word == e.word && out_kind == e.kind, "R3 marker", out_word, e.word);
            else if (e.zeroed)
               check(out_word == '0 && out_kind == 2'd0, "R2 zeroed data", out_word, 0);
            else
               check(out_word == e.word && out_kind == 2'd0, "R1 data pass", out_word, e.word);
            if (e.closes) begin
               check(field_size == e.size, "R5 field size", field_size, e.size);
               check(field_trunc == e.trunc, "R6 trunc flag", field_trunc, e.trunc);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
      check(field_size == '0, "R9 field_size", field_size, 0);
      check(field_trunc == 1'b0, "R9 field_trunc", field_trunc, 0);
      rst_n = 1'b1;
      idle(2);

      // R8: disabled, long field, nothing zeroed
      cfg_en = 1'b0; cfg_limit = 6'd3;
      field(8, 3, 32'h100);
      // R8: enabled but limit 0
      cfg_en = 1'b1; cfg_limit = 6'd0;
      field(6, 0, 32'h200);
      idle(2);
      // R2/R6: limit 5, markers kept, data after index 5 zeroed
      cfg_limit = 6'd5;
      field(10, 2, 32'h300);
      // R4: next field starts fresh at index 0, under budget -> no truncation
      field(3, 0, 32'h400);
      // boundary: exactly limit words before end of field -> index of EOF = limit, nothing zeroed
      field(5, 0, 32'h500);
      // boundary: limit reached on a marker, next data zeroed
      cfg_limit = 6'd3;
      field(4, 2, 32'h600);
      // data value already zero past the limit still counts as truncated
      send(32'h1, 2'd0); send(32'h2, 2'd0); send(32'h3, 2'd0); send(32'h0, 2'd0);
      send(32'hAAAA, 2'd3); send(32'hF1E1_D001, 2'd2);
      idle(3);
      // R7: saturation with count far beyond 63
      cfg_en = 1'b0;
      field(70, 10, 32'h700);
      // R7: enabled, limit at the max, index saturates at 63 -> zeroed
      cfg_en = 1'b1; cfg_limit = CMAX;
      field(66, 0, 32'h900);
      // empty field: only end of field
      send(32'hF1E1_D002, 2'd2);
      idle(4);
      check(sb.size() == 0, "R1 all words out", sb.size(), 0);
      // R5: value held after idle
      check(field_size == 6'd1, "R5 hold", field_size, 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule